// File: doc/BRIEF.md
# Hierarchical carry-lookahead adder

This block adds two 16-bit unsigned operands and an incoming carry. It returns a 16-bit sum and an outgoing carry. It is purely combinational: it has no clock, no reset and no internal state, and the outputs follow the inputs within the same cycle. It is meant to sit inside a datapath stage wherever a wide add must settle faster than a plain bit-by-bit ripple would allow.

The operands are cut into 4-bit groups. Each group forms a generate term (both bits set) and an OR-form propagate term for every bit. From these it builds all four of its carries as flat sum-of-products expressions over its own carry-in, so no carry inside a group waits on another carry. Only the carry out of each group passes on to the next group up. The sum bits use the XOR of the operand bits with the incoming carry, never the OR-form propagate. The number of groups is a parameter, and the default of four gives the 16-bit width.

Top module: `cla16_adder`

## Requirements
- R1: For every operand pair and carry-in, the 17-bit value {cout, sum} equals the integer a + b + cin.
- R2: A carry-in of 1 adds exactly one: with a = 0xFFFF, b = 0x0000 and cin = 1, the sum is 0x0000 and cout is 1.
- R3: A carry made in one 4-bit group reaches the groups above it. 0x0FFF + 0x0000 + 1 gives 0x1000, and 0x00FF + 0x0001 gives 0x0100, each with cout 0. The carry into group k (bits 4k and up) always equals bit 4k of the sum of the operands' low 4k bits plus cin.
- R4: When every bit position has exactly one operand bit set (b = ~a), the carry-in passes straight through. With cin = 0 the sum is 0xFFFF and cout is 0. With cin = 1 the sum is 0x0000 and cout is 1.
- R5: A bit position where both operand bits are 1 always produces a carry, and its sum bit equals its incoming carry. 0xFFFF + 0xFFFF gives sum 0xFFFE and cout 1 when cin = 0, and sum 0xFFFF and cout 1 when cin = 1. 0x0001 + 0x0001 gives 0x0002.
- R6: With both operands zero, the sum equals cin in bit 0 and zeros elsewhere, and cout is 0.
- R7: Alternating-bit operands add correctly. 0xAAAA + 0xAAAA gives sum 0x5554 with cout 1. 0x5555 + 0x5555 + 1 gives 0xAAAB with cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a carry that starts in the lowest group and must cross every group above it. Random operands rarely line up a full run of propagating positions. The vector table therefore places long propagate runs directly above a single generate or above the carry-in (0x0FFF + 1, 0xFFFF + 1, and complementary operand pairs). A dedicated loop also drives b = ~a for many random values of a with both carry-in values, so the carry travels the whole chain every time. Random vectors then cover the remaining patterns against the integer sum.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Bits per lookahead group; the carry equations are written for four.
    localparam int GRP_W = 4;

    // Per-bit terms of one group.
    typedef struct packed {
        logic [GRP_W-1:0] gen;   // both operand bits set
        logic [GRP_W-1:0] prop;  // OR-form, used only for carries
        logic [GRP_W-1:0] half;  // XOR-form, used only for sums
    } grp_terms_t;

    // Carries of one group: index 0 is the group carry-in, index 4 the carry-out.
    typedef logic [GRP_W:0] grp_carry_t;

    function automatic grp_terms_t make_terms(input logic [GRP_W-1:0] x,
                                              input logic [GRP_W-1:0] y);
        grp_terms_t t;
        t.gen  = x & y;
        t.prop = x | y;
        t.half = x ^ y;
        return t;
    endfunction

endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] x,
    input  logic [GRP_W-1:0] y,
    output grp_terms_t       terms
);

    always_comb begin
        terms = make_terms(x, y);
    end

endmodule

// File: rtl/cla_group4.sv
module cla_group4
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] x,
    input  logic [GRP_W-1:0] y,
    input  logic             c_in,
    output logic [GRP_W-1:0] s,
    output logic             c_out
);

    grp_terms_t t;
    grp_carry_t c;

    cla_bit_terms u_terms (
        .x     (x),
        .y     (y),
        .terms (t)
    );

    // Each carry is a flat sum of products over the group carry-in.
    always_comb begin
        c[0] = c_in;
        c[1] = t.gen[0]
             | (t.prop[0] & c_in);
        c[2] = t.gen[1]
             | (t.prop[1] & t.gen[0])
             | (t.prop[1] & t.prop[0] & c_in);
        c[3] = t.gen[2]
             | (t.prop[2] & t.gen[1])
             | (t.prop[2] & t.prop[1] & t.gen[0])
             | (t.prop[2] & t.prop[1] & t.prop[0] & c_in);
        c[4] = t.gen[3]
             | (t.prop[3] & t.gen[2])
             | (t.prop[3] & t.prop[2] & t.gen[1])
             | (t.prop[3] & t.prop[2] & t.prop[1] & t.gen[0])
             | (t.prop[3] & t.prop[2] & t.prop[1] & t.prop[0] & c_in);
    end

    // Sum uses the XOR-form term; the OR-form would be wrong when both bits are set.
    always_comb begin
        s     = t.half ^ c[GRP_W-1:0];
        c_out = c[GRP_W];
    end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int N_GROUPS = 4
) (
    input  logic [N_GROUPS*4-1:0] a,
    input  logic [N_GROUPS*4-1:0] b,
    input  logic                  cin,
    output logic [N_GROUPS*4-1:0] sum,
    output logic                  cout
);

    localparam int WIDTH = N_GROUPS * GRP_W;

    // Carry into each group; the top entry is the adder carry-out.
    logic [N_GROUPS:0] grp_c;

    assign grp_c[0] = cin;

    for (genvar k = 0; k < N_GROUPS; k++) begin : g_grp
        cla_group4 u_grp (
            .x     (a[k*GRP_W +: GRP_W]),
            .y     (b[k*GRP_W +: GRP_W]),
            .c_in  (grp_c[k]),
            .s     (sum[k*GRP_W +: GRP_W]),
            .c_out (grp_c[k+1])
        );
    end

    assign cout = grp_c[N_GROUPS];

    logic unused_width;
    assign unused_width = (WIDTH == N_GROUPS*4) ? 1'b0 : 1'b1;

endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int N_GROUPS = 4
) (
    input logic [N_GROUPS*4-1:0] a,
    input logic [N_GROUPS*4-1:0] b,
    input logic                  cin,
    input logic [N_GROUPS*4-1:0] sum,
    input logic                  cout,
    input logic [N_GROUPS:0]     grp_c
);

    localparam int W = N_GROUPS * 4;

    logic [W:0] full;
    assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    always_comb begin
        p_sum_exact_r1: assert ({cout, sum} == full);
        if (b == ~a) begin
            p_pass_through_r4: assert (cout == cin && sum == {W{~cin}});
        end
        if ((a & b) == {W{1'b1}}) begin
            p_all_generate_r5: assert (cout && sum == {{(W-1){1'b1}}, cin});
        end
        if (a == '0 && b == '0) begin
            p_zero_operands_r6: assert (!cout && sum == {{(W-1){1'b0}}, cin});
        end
    end

    // Carry into each group matches the arithmetic carry of the bits below it.
    for (genvar k = 1; k < N_GROUPS; k++) begin : g_cc
        localparam logic [W-1:0] MASK = {W{1'b1}} >> (W - 4*k);
        logic [W:0] low;
        assign low = {1'b0, a & MASK} + {1'b0, b & MASK} + {{W{1'b0}}, cin};
        always_comb begin
            p_group_carry_r3: assert (grp_c[k] == low[4*k]);
        end
    end

endmodule

bind cla16_adder cla16_adder_chk #(.N_GROUPS(N_GROUPS)) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .grp_c (grp_c)
);

// File: tb/test_cla16_adder.sv
module test_cla16_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [15:0] a, b, sum;
    logic        cin, cout;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    cla16_adder i_cla16_adder (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    // {req tag, a, b, cin, expected {cout,sum}}
    localparam int NV = 15;
    localparam logic [53:0] VEC [NV] = '{
        {4'd6, 16'h0000, 16'h0000, 1'b0, 17'h00000},  // R6
        {4'd6, 16'h0000, 16'h0000, 1'b1, 17'h00001},  // R6
        {4'd2, 16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R2
        {4'd3, 16'h0FFF, 16'h0000, 1'b1, 17'h01000},  // R3
        {4'd3, 16'h00FF, 16'h0001, 1'b0, 17'h00100},  // R3
        {4'd4, 16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},  // R4
        {4'd4, 16'hAAAA, 16'h5555, 1'b1, 17'h10000},  // R4
        {4'd5, 16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},  // R5
        {4'd5, 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R5
        {4'd5, 16'h0001, 16'h0001, 1'b0, 17'h00002},  // R5
        {4'd7, 16'hAAAA, 16'hAAAA, 1'b0, 17'h15554},  // R7
        {4'd7, 16'h5555, 16'h5555, 1'b1, 17'h0AAAB},  // R7
        {4'd1, 16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1
        {4'd1, 16'h8000, 16'h8000, 1'b0, 17'h10000},  // R1
        {4'd3, 16'hF0F0, 16'h0F10, 1'b0, 17'h10000}   // R3
    };

    task automatic apply(input logic [15:0] va, input logic [15:0] vb,
                         input logic vc, input logic [16:0] exp_v, input int tag);
        @(posedge clk);
        a   = va;
        b   = vb;
        cin = vc;
        @(negedge clk);
        n_run++;
        if ({cout, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL R%0d: a=%h b=%h cin=%0d got %h expected %h",
                     tag, va, vb, vc, {cout, sum}, exp_v);
        end
    endtask

    initial begin
        logic [31:0] rng;
        logic [15:0] ra, rb;
        logic        rc;
        a = '0; b = '0; cin = 1'b0;
        rng = 32'h1ACE_B00C;

        // Initial quiet state: zero operands give zero result (R6).
        apply(16'h0000, 16'h0000, 1'b0, 17'h00000, 6);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0],
                  int'(VEC[i][53:50]));
        end

        // R4: complementary operands, carry travels the full chain.
        for (int i = 0; i < 200; i++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            ra = rng[15:0];
            apply(ra, ~ra, 1'b0, {1'b0, 16'hFFFF}, 4);
            apply(ra, ~ra, 1'b1, {1'b1, 16'h0000}, 4);
        end

        // R1: random operands against the integer sum.
        for (int i = 0; i < 3000; i++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            ra = rng[15:0];
            rb = rng[31:16];
            rc = rng[7] ^ rng[22];
            apply(ra, rb, rc, 17'({1'b0, ra} + {1'b0, rb} + {16'd0, rc}), 1);
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule